// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

The block searches one group of eight page table entries for a translation. The caller supplies the byte address of the group, the table-select bit (primary or secondary hash), the compare tag and the entry format (32-bit or 64-bit). It also says whether the access is a store. The block then walks the entries in index order through a read port that allows one request in flight. Each entry is a word pair: a tag/control word and a translation word.

The first entry whose tag/control word qualifies becomes the hit. Every later qualifying entry must agree with it in the translation fields, or the search ends with an inconsistency error. When no entry qualifies, the block reports a miss. On a hit, the referenced flag is set, and the changed flag is set for stores. The translation word goes back to memory only if one of those flags actually moved. The result stays on the outputs until the next start.

Top module: `hpt_group_scan`

## Requirements
- R1: Entry i's tag/control word is read at grp_base + 8*i in 32-bit mode and at grp_base + 16*i in 64-bit mode. Its translation word is read at +4 or +8 from that address, and only when the tag/control word qualifies. Reads go in index order 0 to 7. In 32-bit mode only the low 32 bits of a returned word are used.
- R2: A tag/control word qualifies only if its valid bit is set and its hash-select bit equals tbl_sel. The valid bit is bit 31 in 32-bit mode and bit 0 in 64-bit mode. The hash-select bit is bit 6 in 32-bit mode and bit 1 in 64-bit mode.
- R3: A qualifying word must also equal cmp_tag after masking: 0x7FFFFFBF in 32-bit mode, 0xFFFFFFFFFFFFFF80 in 64-bit mode.
- R4: The lowest-index qualifying entry is the hit, and hit_idx gives its index. After a hit the scan still covers all eight entries unless an inconsistency ends it.
- R5: A later qualifying entry may differ from the hit's translation word in a checked bit. The checked bits are the page-number bits (bit 12 and up) plus mask 0x7B in 32-bit mode (bits 12..31 only), or plus mask 0x7F in 64-bit mode. Such a difference ends the search at once with incons=1, hit=0, xlat_word=0 and no write.
- R6: If no entry qualifies, the search ends with miss=1, hit=0 and xlat_word=0, after exactly eight reads.
- R7: On a hit, xlat_word is the hit's translation word with bit 8 (referenced) set, and with bit 7 (changed) also set when is_store=1.
- R8: On a hit, exactly one write is issued if and only if the flag update changes the word. It goes to the hit's translation word address in the current mode's stride, carries the updated word, and completes before done rises.
- R9: done and the results stay constant until the next start. A start while a search is running is ignored.
- R10: After reset, done, hit, miss, incons, rd_valid and wr_valid are all 0.
- R11: At most one read is outstanding, and a read request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (taken only when idle) |
| grp_base | input | ADDR_W | Byte address of entry 0 of the group |
| tbl_sel | input | 1 | Expected hash-select value |
| cmp_tag | input | 64 | Compare tag |
| wide_mode | input | 1 | 1 = 64-bit entries, 0 = 32-bit entries |
| is_store | input | 1 | Access is a store (sets changed flag) |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Read data |
| wr_valid | output | 1 | Write-back request valid |
| wr_addr | output | ADDR_W | Write-back byte address |
| wr_data | output | 64 | Write-back data |
| wr_ready | input | 1 | Write-back accepted |
| done | output | 1 | Search finished |
| hit | output | 1 | Translation found |
| miss | output | 1 | No qualifying entry |
| incons | output | 1 | Qualifying entries disagree |
| hit_idx | output | 3 | Index of the hit entry |
| xlat_word | output | 64 | Updated translation word on a hit, else 0 |

## Verification
A wrong scan index or stride shows on rd_addr at the very next request, before any result exists. A wrong qualify decision shows in the same search: the translation-word read appears or is missing right after the tag/control response. A stale first-hit register or a lost consistency compare only shows at done, as a wrong hit_idx, xlat_word or result class. The write port exposes a wrong flag-update decision within a cycle of the scan ending.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FLAG, ST_WB} scan_state_t;

  localparam int VALID_BIT_N = 31;
  localparam int HSEL_BIT_N  = 6;
  localparam int VALID_BIT_W = 0;
  localparam int HSEL_BIT_W  = 1;
  localparam int REF_BIT     = 8;
  localparam int CHG_BIT     = 7;

  localparam logic [63:0] TAG_MASK_N = 64'h0000_0000_7FFF_FFBF;
  localparam logic [63:0] TAG_MASK_W = 64'hFFFF_FFFF_FFFF_FF80;
  localparam logic [63:0] LOW_CHK_N  = 64'h7B;
  localparam logic [63:0] LOW_CHK_W  = 64'h7F;

  localparam int STRIDE_SH_N = 3;
  localparam int STRIDE_SH_W = 4;
  localparam int WORD1_OFF_N = 4;
  localparam int WORD1_OFF_W = 8;
endpackage

// File: rtl/hpt_addr_gen.sv
`timescale 1ns/1ps
module hpt_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              second,
  input  logic              mode64,
  output logic [ADDR_W-1:0] addr
);
  import hpt_pkg::*;

  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] ent_off;
  logic [ADDR_W-1:0] word_off;

  assign idx_ext = ADDR_W'(idx);

  always_comb begin
    ent_off  = mode64 ? (idx_ext << STRIDE_SH_W) : (idx_ext << STRIDE_SH_N);
    word_off = '0;
    if (second) word_off = mode64 ? ADDR_W'(WORD1_OFF_W) : ADDR_W'(WORD1_OFF_N);
    addr = base + ent_off + word_off;
  end
endmodule

// File: rtl/hpt_entry_eval.sv
`timescale 1ns/1ps
module hpt_entry_eval #(
  parameter int PAGE_SHIFT = 12
) (
  input  logic        mode64,
  input  logic        tbl_sel,
  input  logic [63:0] tag,
  input  logic [63:0] word,
  input  logic [63:0] ref_word,
  output logic        cand,
  output logic        clash
);
  import hpt_pkg::*;

  localparam logic [63:0] PAGE_MASK = ~((64'd1 << PAGE_SHIFT) - 64'd1);
  localparam logic [63:0] CHK_N = (PAGE_MASK & 64'h0000_0000_FFFF_FFFF) | LOW_CHK_N;
  localparam logic [63:0] CHK_W = PAGE_MASK | LOW_CHK_W;

  logic        vbit;
  logic        hbit;
  logic [63:0] tmask;
  logic [63:0] cmask;

  always_comb begin
    vbit  = mode64 ? word[VALID_BIT_W] : word[VALID_BIT_N];
    hbit  = mode64 ? word[HSEL_BIT_W]  : word[HSEL_BIT_N];
    tmask = mode64 ? TAG_MASK_W : TAG_MASK_N;
    cmask = mode64 ? CHK_W : CHK_N;
    cand  = vbit && (hbit == tbl_sel) && ((word & tmask) == tag);
    clash = ((word ^ ref_word) & cmask) != 64'd0;
  end
endmodule

// File: rtl/hpt_flag_upd.sv
`timescale 1ns/1ps
module hpt_flag_upd (
  input  logic [63:0] word,
  input  logic        is_write,
  output logic [63:0] updated,
  output logic        changed
);
  import hpt_pkg::*;

  always_comb begin
    updated = word;
    updated[REF_BIT] = 1'b1;
    if (is_write) updated[CHG_BIT] = 1'b1;
    changed = (updated != word);
  end
endmodule

// File: rtl/hpt_group_scan.sv
`timescale 1ns/1ps
module hpt_group_scan #(
  parameter int ADDR_W     = 32,
  parameter int GROUP_SIZE = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] grp_base,
  input  logic              tbl_sel,
  input  logic [63:0]       cmp_tag,
  input  logic              wide_mode,
  input  logic              is_store,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  input  logic              wr_ready,
  output logic              done,
  output logic              hit,
  output logic              miss,
  output logic              incons,
  output logic [2:0]        hit_idx,
  output logic [63:0]       xlat_word
);
  import hpt_pkg::*;

  localparam int IDX_W = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_SIZE - 1);

  scan_state_t       state_q;
  logic [ADDR_W-1:0] base_q;
  logic              tbl_q;
  logic [63:0]       tag_q;
  logic              mode_q;
  logic              store_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wsel_q;
  logic              have_q;
  logic [63:0]       ref_q;
  logic [IDX_W-1:0]  hidx_q;
  logic [63:0]       wb_q;

  logic [63:0]       rsp_w;
  logic              cand;
  logic              clash;
  logic [63:0]       upd_word;
  logic              upd_chg;
  logic [IDX_W-1:0]  ag_idx;
  logic              ag_second;
  logic [ADDR_W-1:0] ag_addr;

  assign rsp_w = mode_q ? rsp_data : {32'd0, rsp_data[31:0]};

  hpt_entry_eval #(.PAGE_SHIFT(PAGE_SHIFT)) eval_i (
    .mode64  (mode_q),
    .tbl_sel (tbl_q),
    .tag     (tag_q),
    .word    (rsp_w),
    .ref_word(ref_q),
    .cand    (cand),
    .clash   (clash)
  );

  hpt_flag_upd flag_i (
    .word    (ref_q),
    .is_write(store_q),
    .updated (upd_word),
    .changed (upd_chg)
  );

  assign ag_idx    = (state_q == ST_WB) ? hidx_q : idx_q;
  assign ag_second = (state_q == ST_WB) ? 1'b1 : wsel_q;

  hpt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
    .base  (base_q),
    .idx   (ag_idx),
    .second(ag_second),
    .mode64(mode_q),
    .addr  (ag_addr)
  );

  assign rd_valid = (state_q == ST_REQ);
  assign rd_addr  = ag_addr;
  assign wr_valid = (state_q == ST_WB);
  assign wr_addr  = ag_addr;
  assign wr_data  = wb_q;
  assign hit_idx  = 3'(hidx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      tbl_q     <= 1'b0;
      tag_q     <= '0;
      mode_q    <= 1'b0;
      store_q   <= 1'b0;
      idx_q     <= '0;
      wsel_q    <= 1'b0;
      have_q    <= 1'b0;
      ref_q     <= '0;
      hidx_q    <= '0;
      wb_q      <= '0;
      done      <= 1'b0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      incons    <= 1'b0;
      xlat_word <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q    <= grp_base;
            tbl_q     <= tbl_sel;
            tag_q     <= cmp_tag;
            mode_q    <= wide_mode;
            store_q   <= is_store;
            idx_q     <= '0;
            wsel_q    <= 1'b0;
            have_q    <= 1'b0;
            ref_q     <= '0;
            hidx_q    <= '0;
            done      <= 1'b0;
            hit       <= 1'b0;
            miss      <= 1'b0;
            incons    <= 1'b0;
            xlat_word <= '0;
            state_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!wsel_q && cand) begin
              wsel_q  <= 1'b1;
              state_q <= ST_REQ;
            end else if (wsel_q && have_q && clash) begin
              incons  <= 1'b1;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              if (wsel_q && !have_q) begin
                have_q <= 1'b1;
                ref_q  <= rsp_w;
                hidx_q <= idx_q;
              end
              wsel_q <= 1'b0;
              if (idx_q == LAST_IDX) begin
                state_q <= ST_FLAG;
              end else begin
                idx_q   <= idx_q + IDX_W'(1);
                state_q <= ST_REQ;
              end
            end
          end
        end
        ST_FLAG: begin
          if (!have_q) begin
            miss    <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (upd_chg) begin
            wb_q    <= upd_word;
            state_q <= ST_WB;
          end else begin
            hit       <= 1'b1;
            xlat_word <= upd_word;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_WB: begin
          if (wr_ready) begin
            hit       <= 1'b1;
            xlat_word <= wb_q;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_group_scan_chk.sv
`timescale 1ns/1ps
module hpt_group_scan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data,
  input logic              wr_ready,
  input logic              done,
  input logic              hit,
  input logic              miss,
  input logic              incons,
  input logic [2:0]        hit_idx,
  input logic [63:0]       xlat_word
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (rd_valid && rd_ready) pend_q <= 1'b1;
    else if (rsp_valid) pend_q <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done && !hit && !miss && !incons && !rd_valid && !wr_valid)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) pend_q |-> !rd_valid); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
  AST_WB_HAS_REF: assert property (@(posedge clk) disable iff (rst) wr_valid |-> wr_data[8]); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst) done |-> ($countones({hit, miss, incons}) == 1)); // R4
  AST_RESULT_GATED: assert property (@(posedge clk) disable iff (rst) (hit || miss || incons) |-> done); // R9
  AST_FAIL_NO_XLAT: assert property (@(posedge clk) disable iff (rst) (done && !hit) |-> (xlat_word == 64'd0)); // R5
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst) done |-> (!rd_valid && !wr_valid)); // R9
  AST_DONE_STABLE: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> (done && $stable({hit, miss, incons, hit_idx, xlat_word}))); // R9
endmodule

bind hpt_group_scan hpt_group_scan_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start(start),
  .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
  .done(done), .hit(hit), .miss(miss), .incons(incons), .hit_idx(hit_idx), .xlat_word(xlat_word)
);

// File: tb/hpt_group_scan_tb.sv
`timescale 1ns/1ps
module hpt_group_scan_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic          tbl_in = 1'b0;
  logic [63:0]   tag_in = '0;
  logic          mode_in = 1'b0;
  logic          st_in = 1'b0;
  logic          rd_valid, wr_valid, done, hit, miss, incons;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          rd_ready = 1'b0, rsp_valid = 1'b0, wr_ready = 1'b0;
  logic [63:0]   rsp_data = '0, wr_data, xlat_word;
  logic [2:0]    hit_idx;

  always #2.5 clk = ~clk;

  hpt_group_scan #(.ADDR_W(AW), .GROUP_SIZE(8), .PAGE_SHIFT(12)) dut_i (
    .clk(clk), .rst(rst), .start(start), .grp_base(base_in), .tbl_sel(tbl_in),
    .cmp_tag(tag_in), .wide_mode(mode_in), .is_store(st_in),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .done(done), .hit(hit), .miss(miss), .incons(incons), .hit_idx(hit_idx), .xlat_word(xlat_word)
  );

  logic [31:0] mem [0:255];
  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] rseed = 32'h0bad_f00d;

  // scenario context
  logic          cur_mode;
  logic [AW-1:0] cur_base;
  logic          cur_tbl, cur_st;
  logic [63:0]   cur_tag;
  // expectations
  logic          e_hit, e_miss, e_incons, e_wb;
  logic [2:0]    e_idx;
  logic [63:0]   e_xlat, e_wb_data;
  logic [AW-1:0] e_wb_addr;
  logic [AW-1:0] e_rd_addr [0:15];
  int            e_rd_n;
  // observations
  int rd_n, wr_n, rd_bad, rsp_cnt;
  logic [AW-1:0] got_wr_addr;
  logic [63:0]   got_wr_data, rsp_q;

  function automatic logic [31:0] nxt(inout logic [31:0] s);
    s = s * 32'd1103515245 + 32'd12345;
    return s;
  endfunction

  function automatic logic [63:0] rdw(logic m, logic [AW-1:0] a);
    int i = int'(a[9:2]);
    if (m) return {mem[(i + 1) % 256], mem[i]};
    return {32'd0, mem[i]};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder, driven at negedge so the next posedge sees stable values
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin rsp_valid = 1'b1; rsp_data = rsp_q; end
      end
      rd_ready = nxt(rseed)[20] | nxt(rseed)[21];
      if (rd_valid && rd_ready) begin
        if (rd_n >= e_rd_n || rd_addr != e_rd_addr[rd_n % 16]) rd_bad++;
        rd_n++;
        rsp_q   = rdw(cur_mode, rd_addr);
        rsp_cnt = 1 + int'(nxt(rseed)[18:17] % 3);
      end
      wr_ready = nxt(rseed)[22];
      if (wr_valid && wr_ready) begin
        wr_n++;
        got_wr_addr = wr_addr;
        got_wr_data = wr_data;
        mem[int'(wr_addr[9:2])] = wr_data[31:0];
        if (cur_mode) mem[(int'(wr_addr[9:2]) + 1) % 256] = wr_data[63:32];
      end
    end
  end

  // independent model of the requirements
  task automatic model();
    logic have = 1'b0;
    logic [63:0] refw = '0, w0, w1, tm, cm, pm;
    logic [AW-1:0] a0;
    logic v, h;
    e_rd_n = 0; e_incons = 0; e_idx = 0;
    pm = ~64'hFFF;
    tm = cur_mode ? 64'hFFFF_FFFF_FFFF_FF80 : 64'h7FFF_FFBF;
    cm = cur_mode ? (pm | 64'h7F) : ((pm & 64'hFFFF_FFFF) | 64'h7B);
    for (int i = 0; i < 8; i++) begin
      a0 = cur_base + AW'(cur_mode ? 16 * i : 8 * i);
      w0 = rdw(cur_mode, a0);
      e_rd_addr[e_rd_n] = a0; e_rd_n++;
      v = cur_mode ? w0[0] : w0[31];
      h = cur_mode ? w0[1] : w0[6];
      if (v && h == cur_tbl && (w0 & tm) == cur_tag) begin
        e_rd_addr[e_rd_n] = a0 + AW'(cur_mode ? 8 : 4); e_rd_n++;
        w1 = rdw(cur_mode, a0 + AW'(cur_mode ? 8 : 4));
        if (have) begin
          if (((w1 ^ refw) & cm) != 0) begin e_incons = 1; break; end
        end else begin
          have = 1; refw = w1; e_idx = 3'(i);
          e_wb_addr = a0 + AW'(cur_mode ? 8 : 4);
        end
      end
    end
    e_hit  = have && !e_incons;
    e_miss = !have;
    e_xlat = e_hit ? (refw | 64'h100 | (cur_st ? 64'h80 : 64'h0)) : 64'd0;
    e_wb   = e_hit && (e_xlat != refw);
    e_wb_data = e_xlat;
  endtask

  // kind codes: 0-1 invalid, 2-3 wrong hash bit, 4-5 wrong tag, 6-9 match,
  // 10-11 match with R/C differences, 12 match bit2 diff, 13 match page diff, 14-15 zero
  function automatic int kind_of(int sc, int i);
    case (sc)
      0: return 14;
      1: return (i == 7) ? 6 : 2;
      2: return (i == 0) ? 6 : (i == 5) ? 13 : 4;
      3: return (i == 0) ? 6 : 0;
      default: return int'(nxt(seed)[27:24]);
    endcase
  endfunction

  task automatic build(int sc);
    logic [63:0] w1b, w0m, w0, w1;
    logic [AW-1:0] a;
    int k;
    cur_mode = sc[0]; cur_tbl = sc[1]; cur_st = (sc == 3) ? 1'b0 : sc[2];
    cur_base = AW'(16'h0080 + (sc % 4) * 16'h0080);
    cur_tag = cur_mode ? ({nxt(seed), nxt(seed)} & 64'hFFFF_FFFF_FFFF_FF80)
                       : {32'd0, nxt(seed) & 32'h7FFF_FFBF};
    w1b = cur_mode ? {nxt(seed), nxt(seed)} : {32'd0, nxt(seed)};
    w1b[8:7] = (sc == 3) ? 2'b11 : nxt(seed)[9:8];
    for (int i = 0; i < 8; i++) begin
      k = kind_of(sc, i);
      w0m = cur_mode ? (cur_tag | 64'h1 | {62'd0, cur_tbl, 1'b0} | (64'(nxt(seed)) & 64'h7C))
                     : (cur_tag | 64'h8000_0000 | {57'd0, cur_tbl, 6'd0});
      w0 = w0m; w1 = w1b;
      if (k <= 1) w0 = cur_mode ? (w0m & ~64'h1) : (w0m & ~64'h8000_0000);
      else if (k <= 3) w0 = cur_mode ? (w0m ^ 64'h2) : (w0m ^ 64'h40);
      else if (k <= 5) w0 = w0m ^ 64'h10_0000;
      else if (k <= 9) w1 = w1b;
      else if (k <= 11) w1 = w1b ^ (64'(nxt(seed)) & 64'h180);
      else if (k == 12) w1 = w1b ^ 64'h4;
      else if (k == 13) w1 = w1b ^ 64'h1000;
      else w0 = 64'd0;
      if (k <= 5 || k >= 14) w1 = cur_mode ? {nxt(seed), nxt(seed)} : {32'd0, nxt(seed)};
      a = cur_base + AW'(cur_mode ? 16 * i : 8 * i);
      if (cur_mode) begin
        mem[int'(a[9:2])] = w0[31:0]; mem[int'(a[9:2]) + 1] = w0[63:32];
        mem[int'(a[9:2]) + 2] = w1[31:0]; mem[int'(a[9:2]) + 3] = w1[63:32];
      end else begin
        mem[int'(a[9:2])] = w0[31:0]; mem[int'(a[9:2]) + 1] = w1[31:0];
      end
    end
  endtask

  task automatic run(int sc, bit poke);
    int t = 0;
    logic [9:0] snap;
    logic [63:0] xsnap;
    build(sc);
    model();
    rd_n = 0; wr_n = 0; rd_bad = 0;
    @(negedge clk);
    base_in = cur_base; tbl_in = cur_tbl; tag_in = cur_tag; mode_in = cur_mode; st_in = cur_st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      base_in = cur_base + AW'(16'h40); tag_in = ~cur_tag; tbl_in = ~cur_tbl;
      start = 1'b1;                               // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R9 done timeout", {63'd0, done}, 64'd1);
    chk(hit == e_hit && miss == e_miss && incons == e_incons,
        "R2 R3 R4 R5 R6 result class", {61'd0, hit, miss, incons}, {61'd0, e_hit, e_miss, e_incons});
    if (e_hit) chk(hit_idx == e_idx, "R4 hit index", 64'(hit_idx), 64'(e_idx));
    chk(xlat_word == e_xlat, "R7 translation word", xlat_word, e_xlat);
    chk(rd_n == e_rd_n && rd_bad == 0, "R1 read sequence", 64'(rd_n), 64'(e_rd_n));
    if (e_wb) chk(wr_n == 1 && got_wr_addr == e_wb_addr && got_wr_data == e_wb_data,
                  "R8 write-back", got_wr_data, e_wb_data);
    else chk(wr_n == 0, "R8 no write-back", 64'(wr_n), 64'd0);
    snap = {hit, miss, incons, hit_idx, done, 3'd0};
    xsnap = xlat_word;
    repeat (3) @(negedge clk);
    chk({hit, miss, incons, hit_idx, done, 3'd0} == snap && xlat_word == xsnap,
        "R9 result held", 64'({hit, miss, incons, hit_idx, done}), 64'(snap[9:3]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    rsp_cnt = 0; e_rd_n = 0; rd_n = 0; wr_n = 0; rd_bad = 0;
    repeat (4) @(negedge clk);
    chk(!done && !hit && !miss && !incons && !rd_valid && !wr_valid, "R10 reset state",
        {58'd0, done, hit, miss, incons, rd_valid, wr_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !rd_valid && !wr_valid, "R10 idle after reset",
        {61'd0, done, rd_valid, wr_valid}, 64'd0);
    for (int sc = 0; sc < 240; sc++) run(sc, (sc % 5) == 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule